// File: doc/BRIEF.md
# Repeated-Subtraction Unsigned Divider

A sequential unsigned divider that works by repeated subtraction, not by shifting. A one-cycle start request captures a dividend and a divisor. The block then subtracts the divisor from a working value once per clock and counts each subtraction. The first subtraction that underflows is undone on the following clock: the divisor is added back and the count is stepped down by one. At that point the working value is the remainder and the count is the quotient.

The operand width is a parameter, 8 or 16 bits. The subtractor is built from 8-bit lanes. Each lane passes its borrow to the next lane up, so the 16-bit build subtracts the low byte first and then the high byte with borrow.

Busy, a one-cycle done pulse and an error flag report the operation. The error flag marks a zero divisor, which the block answers at once without looping.

Top module: `rsub_divider`

## Requirements
- R1: After reset, busy_o, done_o, err_o, quotient_o and remainder_o are all zero.
- R2: A start accepted while idle with a nonzero divisor gives done_o exactly quotient+2 clock edges after the edge that sampled start_i.
- R3: For a nonzero divisor, quotient_o times the divisor plus remainder_o equals the dividend, remainder_o is less than the divisor, and err_o is 0.
- R4: A dividend smaller than the divisor gives quotient 0 and a remainder equal to the dividend, after a latency of 2.
- R5: A zero divisor sets err_o to 1, quotient_o to all ones and remainder_o to the dividend, with done_o one edge after the start edge.
- R6: busy_o is high from the edge after start until done_o rises, and it is low in the done_o cycle.
- R7: done_o is high for exactly one cycle per operation.
- R8: quotient_o, remainder_o and err_o change only in the cycle in which done_o is high, and hold their values between done pulses.
- R9: start_i asserted while busy_o is high is ignored. The running operation finishes with its own operands and keeps its latency.
- R10: In the 16-bit build, a borrow from the low byte propagates into the high byte, so results are correct across the byte boundary (0x0100 / 0x0001 = 256 rem 0).
- R11: A valid operation that follows a zero-divisor operation clears err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled only while idle |
| dividend_i | input | WIDTH | Dividend, captured on start |
| divisor_i | input | WIDTH | Divisor, captured on start |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last operation had a zero divisor |
| quotient_o | output | WIDTH | Quotient of the last operation |
| remainder_o | output | WIDTH | Remainder of the last operation |

## Verification
The bench builds two instances side by side, one with WIDTH=8 and one with WIDTH=16. The 8-bit instance reaches the largest quotient against its latency: all ones divided by one takes 257 cycles. The 16-bit instance exercises the chain of lane borrows across the byte boundary. It also covers quotients in the thousands, where the quotient+2 latency rule is measured over long runs.

// File: rtl/rsub_pkg.sv
package rsub_pkg;
  localparam int LANE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SUB  = 2'd1,
    ST_FIX  = 2'd2,
    ST_ZERO = 2'd3
  } rsub_state_e;
endpackage

// File: rtl/rsub_lane_sub.sv
// Lane-chained subtract: low lane first, borrow ripples upward.
module rsub_lane_sub #(
  parameter int WIDTH = 8,
  parameter int LANE  = rsub_pkg::LANE_W
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] diff_o,
  output logic             borrow_o
);
  localparam int NLANE = WIDTH / LANE;

  logic [NLANE:0] brw;
  assign brw[0] = 1'b0;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    logic [LANE:0] ext;
    assign ext = {1'b0, a_i[g*LANE +: LANE]} - {1'b0, b_i[g*LANE +: LANE]}
               - {{LANE{1'b0}}, brw[g]};
    assign diff_o[g*LANE +: LANE] = ext[LANE-1:0];
    assign brw[g+1] = ext[LANE];
  end

  assign borrow_o = brw[NLANE];
endmodule

// File: rtl/rsub_work_path.sv
module rsub_work_path #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  logic             fix_i,
  input  logic [WIDTH-1:0] dividend_i,
  input  logic [WIDTH-1:0] divisor_i,
  output logic [WIDTH-1:0] work_o,
  output logic             borrow_o,
  output logic [WIDTH-1:0] fix_rem_o,
  output logic [WIDTH-1:0] fix_quo_o
);
  localparam int CNT_W = WIDTH + 1;  // count reaches 2^WIDTH before restore

  logic [WIDTH-1:0] work_q;
  logic [CNT_W-1:0] cnt_q;
  logic [WIDTH-1:0] diff;
  logic [CNT_W-1:0] cnt_dec;

  rsub_lane_sub #(.WIDTH(WIDTH)) u_sub (
    .a_i      (work_q),
    .b_i      (divisor_i),
    .diff_o   (diff),
    .borrow_o (borrow_o)
  );

  assign fix_rem_o = work_q + divisor_i;
  assign cnt_dec   = cnt_q - CNT_W'(1);
  assign fix_quo_o = cnt_dec[WIDTH-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      work_q <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      work_q <= dividend_i;
      cnt_q  <= '0;
    end else if (step_i) begin
      work_q <= diff;
      cnt_q  <= cnt_q + CNT_W'(1);
    end else if (fix_i) begin
      work_q <= fix_rem_o;
      cnt_q  <= cnt_dec;
    end
  end

  assign work_o = work_q;
endmodule

// File: rtl/rsub_ctrl.sv
module rsub_ctrl
  import rsub_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic div_zero_i,
  input  logic borrow_i,
  output logic load_o,
  output logic step_o,
  output logic fix_o,
  output logic zero_fin_o,
  output logic busy_o
);
  rsub_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = div_zero_i ? ST_ZERO : ST_SUB;
      ST_SUB:  if (borrow_i) state_d = ST_FIX;
      ST_FIX:  state_d = ST_IDLE;
      ST_ZERO: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign load_o     = (state_q == ST_IDLE) && start_i;
  assign step_o     = (state_q == ST_SUB);
  assign fix_o      = (state_q == ST_FIX);
  assign zero_fin_o = (state_q == ST_ZERO);
  assign busy_o     = (state_q != ST_IDLE);
endmodule

// File: rtl/rsub_divider.sv
module rsub_divider #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [WIDTH-1:0] dividend_i,
  input  logic [WIDTH-1:0] divisor_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [WIDTH-1:0] quotient_o,
  output logic [WIDTH-1:0] remainder_o
);
  logic             load, step, fix, zero_fin, borrow;
  logic [WIDTH-1:0] div_q;
  logic [WIDTH-1:0] work, fix_rem, fix_quo;
  logic             done_q, err_q;
  logic [WIDTH-1:0] quo_q, rem_q;

  rsub_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .div_zero_i (divisor_i == '0),
    .borrow_i   (borrow),
    .load_o     (load),
    .step_o     (step),
    .fix_o      (fix),
    .zero_fin_o (zero_fin),
    .busy_o     (busy_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   div_q <= '0;
    else if (load) div_q <= divisor_i;
  end

  rsub_work_path #(.WIDTH(WIDTH)) u_path (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .step_i     (step),
    .fix_i      (fix),
    .dividend_i (dividend_i),
    .divisor_i  (div_q),
    .work_o     (work),
    .borrow_o   (borrow),
    .fix_rem_o  (fix_rem),
    .fix_quo_o  (fix_quo)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      quo_q  <= '0;
      rem_q  <= '0;
    end else begin
      done_q <= fix | zero_fin;
      if (fix) begin
        quo_q <= fix_quo;
        rem_q <= fix_rem;
        err_q <= 1'b0;
      end else if (zero_fin) begin
        quo_q <= '1;
        rem_q <= work;
        err_q <= 1'b1;
      end
    end
  end

  assign done_o      = done_q;
  assign err_o       = err_q;
  assign quotient_o  = quo_q;
  assign remainder_o = rem_q;
endmodule

// File: rtl/rsub_divider_chk.sv
module rsub_divider_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_i,
  input logic             done_i,
  input logic             err_i,
  input logic [WIDTH-1:0] quo_i,
  input logic [WIDTH-1:0] rem_i,
  input logic [WIDTH-1:0] div_lat_i
);
  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  assert_busy_low_at_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> !busy_i);

  assert_busy_after_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_i) |=> busy_i);

  assert_result_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |-> ($stable(quo_i) && $stable(rem_i) && $stable(err_i)));

  assert_zero_div_quo_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && err_i) |-> (quo_i == {WIDTH{1'b1}}));

  assert_rem_below_div_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !err_i) |-> (rem_i < div_lat_i));

  assert_start_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(div_lat_i));
endmodule

bind rsub_divider rsub_divider_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .busy_i    (busy_o),
  .done_i    (done_o),
  .err_i     (err_o),
  .quo_i     (quotient_o),
  .rem_i     (remainder_o),
  .div_lat_i (div_q)
);

// File: tb/rsub_divider_tb.sv
module rsub_divider_tb;
  localparam int CLK_P = 10;
  localparam int NV = 12;
  localparam bit VW [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
                             1'b1, 1'b1, 1'b1, 1'b1, 1'b1};
  localparam logic [15:0] VA [NV] = '{16'd100, 16'd255, 16'd0, 16'd3, 16'd255, 16'd17,
                                      16'd200, 16'h1234, 16'h0100, 16'h1000, 16'h00FF,
                                      16'hFFFF};
  localparam logic [15:0] VB [NV] = '{16'd7, 16'd1, 16'd5, 16'd200, 16'd255, 16'd17,
                                      16'd16, 16'd3, 16'h0001, 16'h00FF, 16'h0100,
                                      16'h0FFF};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic st8 = 1'b0, st16 = 1'b0;
  logic [7:0] a8 = '0, b8 = '0;
  logic [15:0] a16 = '0, b16 = '0;
  logic bz8, dn8, er8, bz16, dn16, er16;
  logic [7:0] q8, r8;
  logic [15:0] q16, r16;
  logic sel = 1'b0;
  int checks = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;

  rsub_divider #(.WIDTH(8)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(st8), .dividend_i(a8), .divisor_i(b8),
    .busy_o(bz8), .done_o(dn8), .err_o(er8), .quotient_o(q8), .remainder_o(r8));

  rsub_divider #(.WIDTH(16)) u_dut16 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(st16), .dividend_i(a16), .divisor_i(b16),
    .busy_o(bz16), .done_o(dn16), .err_o(er16), .quotient_o(q16), .remainder_o(r16));

  logic cur_busy, cur_done, cur_err;
  logic [15:0] cur_q, cur_r;
  assign cur_busy = sel ? bz16 : bz8;
  assign cur_done = sel ? dn16 : dn8;
  assign cur_err  = sel ? er16 : er8;
  assign cur_q    = sel ? q16 : {8'h00, q8};
  assign cur_r    = sel ? r16 : {8'h00, r8};

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input bit w, input logic [15:0] a, input logic [15:0] b,
                        input bit poke, input string req);
    logic [15:0] mask, eq, er, hq, hr;
    int exp_lat, lat;
    bit busy_bad, seen;
    mask = w ? 16'hFFFF : 16'h00FF;
    eq = (b == 0) ? mask : a / b;
    er = (b == 0) ? a : a % b;
    exp_lat = (b == 0) ? 1 : int'(eq) + 2;
    @(negedge clk);
    sel = w;
    if (w) begin a16 = a; b16 = b; st16 = 1'b1; end
    else   begin a8 = a[7:0]; b8 = b[7:0]; st8 = 1'b1; end
    @(posedge clk); #1;
    st8 = 1'b0; st16 = 1'b0;
    lat = 0; busy_bad = 0; seen = 0;
    while (!seen && lat < 70000) begin
      @(posedge clk); #1;
      lat++;
      if (poke && lat == 1) begin
        // start while busy with other operands: must be ignored (R9)
        if (w) begin a16 = 16'd5; b16 = 16'd1; st16 = 1'b1; end
        else   begin a8 = 8'd5; b8 = 8'd1; st8 = 1'b1; end
      end else begin
        st8 = 1'b0; st16 = 1'b0;
      end
      if (cur_done) seen = 1;
      else if (!cur_busy) busy_bad = 1;
    end
    chk(seen, "R2", "done seen", 32'(seen), 32'd1);
    chk(lat == exp_lat, "R2", {req, " latency"}, 32'(lat), 32'(exp_lat));
    chk(cur_q == eq, req, "quotient", 32'(cur_q), 32'(eq));
    chk(cur_r == er, req, "remainder", 32'(cur_r), 32'(er));
    chk(cur_err == (b == 0), (b == 0) ? "R5" : "R11", "err", 32'(cur_err), 32'(b == 0));
    chk(!cur_busy, "R6", "busy at done", 32'(cur_busy), 32'd0);
    chk(!busy_bad, "R6", "busy during run", 32'(busy_bad), 32'd0);
    hq = cur_q; hr = cur_r;
    @(posedge clk); #1;
    chk(!cur_done, "R7", "done one cycle", 32'(cur_done), 32'd0);
    @(posedge clk); @(posedge clk); #1;
    chk(cur_q == hq && cur_r == hr, "R8", "outputs hold", {cur_q, cur_r}, {hq, hr});
  endtask

  initial begin
    #(CLK_P * 190000);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 3);
    #1;
    chk(!bz8 && !dn8 && !er8 && q8 == 0 && r8 == 0, "R1", "reset state 8",
        {bz8, dn8, er8, q8, r8}, 32'd0);
    chk(!bz16 && !dn16 && !er16 && q16 == 0 && r16 == 0, "R1", "reset state 16",
        {bz16, dn16, er16}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(!bz8 && !dn8 && q8 == 0, "R1", "after release", {bz8, dn8, q8}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (VA[i] < VB[i]) run_op(VW[i], VA[i], VB[i], 1'b0, "R4");
      else if (VW[i] && VA[i] == 16'h0100) run_op(VW[i], VA[i], VB[i], 1'b0, "R10");
      else run_op(VW[i], VA[i], VB[i], 1'b0, "R3");
    end

    run_op(1'b0, 16'd77, 16'd0, 1'b0, "R5");
    run_op(1'b0, 16'd50, 16'd6, 1'b0, "R11");
    run_op(1'b1, 16'hABCD, 16'd0, 1'b0, "R5");
    run_op(1'b1, 16'h0203, 16'h0102, 1'b0, "R11");
    run_op(1'b0, 16'd200, 16'd7, 1'b1, "R9");
    run_op(1'b1, 16'h0300, 16'h0011, 1'b1, "R9");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule